// File: doc/BRIEF.md
# Pulse-Based Bus Grant Arbiter

This block lends a host's local bus to outside bus masters. Each master has one shared, active-low wire to the block. The wire is modelled as three signals: the sampled level, the level the block drives, and a drive enable. A master asks for the bus with a low pulse one clock wide. The block answers on the same wire with its own one-clock low pulse. The bus then belongs to that master until the master sends a third one-clock low pulse, which hands the bus back.

The host bus unit reports its current T-state and three attributes of the cycle in progress: the cycle is the low byte of an odd-address word, the cycle is the first of a pair of interrupt-acknowledge cycles, or a locked instruction is running. From these the block decides when a pending request may take the bus. It tells the host to float its bus drivers while a grant is in force. It also raises a hold flag for the whole time the outside master owns the bus. The lowest channel index wins when several requests are eligible. At least one idle clock separates the return of the bus from the next grant.

Top module: `pulse_grant_arbiter`

## Requirements
- R1: While reset is low and on the first clock after it, every drive enable is low, and `bus_float_o` and `hold_o` are low.
- R2: A request is a falling edge on an idle request line. If the line stays low for several clocks, this counts as a single request, which leads to exactly one grant.
- R3: A grant raises `rqgt_oe_o[i]` for exactly one clock with `rqgt_o[i]` at 0. `bus_float_o` is high and `hold_o` is low in that clock. Outside grant clocks, every drive enable is low.
- R4: From the clock after the grant, `hold_o` and `bus_float_o` stay high until the owner releases the bus.
- R5: A one-clock low pulse from the owning master during hold is a release. `hold_o` and `bus_float_o` are low in the clock that follows the pulse, and no new grant follows unless a request is pending.
- R6: After `hold_o` falls there is at least one clock with no grant. A request already pending from another channel is granted in the clock after that dead clock.
- R7: `tstate_i` is encoded as idle=0, T1=1, T2=2, T3=3, TW=4, T4=5. A grant pulse occurs only in the clock that follows a clock in which `tstate_i` was T4 or idle.
- R8: At T4, the grant is withheld if `odd_lo_i`, `inta_first_i` or `lock_i` is high. `lock_i` also blocks a grant while idle. A blocked request stays pending and is granted at the first later point where nothing blocks it.
- R9: A request sampled while `tstate_i` is T3, TW or T4 is not granted at that cycle's T4. It becomes eligible once the host passes T1 or idle.
- R10: When requests from several channels are eligible in the same clock, the lowest channel index is granted first.
- R11: A reset during hold returns the bus to the host and discards all pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tstate_i | input | 3 | Host T-state (idle=0, T1..T3=1..3, TW=4, T4=5) |
| odd_lo_i | input | 1 | Current cycle is the low byte of an odd-address word |
| inta_first_i | input | 1 | Current cycle is the first interrupt-acknowledge cycle |
| lock_i | input | 1 | A locked instruction is running |
| rqgt_i | input | NCH | Sampled level of each request/grant wire |
| rqgt_o | output | NCH | Level driven onto each wire when enabled (always low) |
| rqgt_oe_o | output | NCH | Drive enable per wire, high only during a grant pulse |
| bus_float_o | output | 1 | Host must float its bus drivers |
| hold_o | output | 1 | An outside master owns the bus |

## Verification
Two things can land on the same clock: requests from both channels, and a request arriving while a handshake is already in progress. The bench pulses both wires in the same clock and expects channel 0 to be granted. It then expects channel 1 to be granted exactly two clocks after channel 0 releases, which leaves one dead clock between them. In a second test, channel 1 holds its wire low for several clocks while channel 0 owns the bus. The bench checks that this yields one grant after the release and no second grant after channel 1 hands the bus back.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam logic [2:0] TS_IDLE = 3'd0;
    localparam logic [2:0] TS_T1   = 3'd1;
    localparam logic [2:0] TS_T2   = 3'd2;
    localparam logic [2:0] TS_T3   = 3'd3;
    localparam logic [2:0] TS_TW   = 3'd4;
    localparam logic [2:0] TS_T4   = 3'd5;

    typedef enum logic [1:0] {
        GS_HOST,
        GS_GRANT,
        GS_HELD,
        GS_DEAD
    } gstate_e;

    typedef struct packed {
        logic prev;
        logic pend;
        logic late;
    } chan_st_t;

    // A request seen in these phases is too late for the current cycle's T4
    function automatic logic in_late_phase(input logic [2:0] ts);
        return (ts == TS_T3) || (ts == TS_TW) || (ts == TS_T4);
    endfunction

    function automatic logic at_cycle_start(input logic [2:0] ts);
        return (ts == TS_IDLE) || (ts == TS_T1);
    endfunction

endpackage

// File: rtl/pga_chan.sv
module pga_chan
    import pga_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       line_i,
    input  logic       drive_i,
    input  logic       owner_held_i,
    input  logic       take_i,
    input  logic [2:0] tstate_i,
    output logic       fall_o,
    output logic       pend_o,
    output logic       late_o
);

    chan_st_t st_d, st_q;
    logic     fall;

    always_comb begin
        st_d = st_q;
        // our own grant pulse on the wire is never taken as a master edge
        fall      = st_q.prev & ~line_i & ~drive_i;
        st_d.prev = drive_i ? 1'b1 : line_i;
        if (take_i) begin
            st_d.pend = 1'b0;
            st_d.late = 1'b0;
        end else if (fall && !owner_held_i && !st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.late = in_late_phase(tstate_i);
        end else if (at_cycle_start(tstate_i)) begin
            st_d.late = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{prev: 1'b1, pend: 1'b0, late: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = fall;
    assign pend_o = st_q.pend;
    assign late_o = st_q.late;

    AST_LATE_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        late_o |-> pend_o);  // R9

    AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> !pend_o);  // R2

endmodule

// File: rtl/pga_prio.sv
module pga_prio #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] elig_i,
    output logic [NCH-1:0] sel_o,
    output logic           any_o
);

    always_comb begin
        sel_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |elig_i;

endmodule

// File: rtl/pga_ctrl.sv
module pga_ctrl
    import pga_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [2:0]     tstate_i,
    input  logic           odd_lo_i,
    input  logic           inta_first_i,
    input  logic           lock_i,
    input  logic [NCH-1:0] pend_i,
    input  logic [NCH-1:0] late_i,
    input  logic [NCH-1:0] fall_i,
    output logic [NCH-1:0] oe_o,
    output logic [NCH-1:0] take_o,
    output logic [NCH-1:0] owner_held_o,
    output logic           float_o,
    output logic           hold_o
);

    typedef struct packed {
        gstate_e        gs;
        logic [NCH-1:0] own;
    } ctl_t;

    ctl_t           c_d, c_q;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] sel;
    logic           any;
    logic           t4_ok;
    logic           idle_ok;

    assign t4_ok   = (tstate_i == TS_T4) && !odd_lo_i && !inta_first_i && !lock_i;
    assign idle_ok = (tstate_i == TS_IDLE) && !lock_i;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            elig[i] = pend_i[i] && ((t4_ok && !late_i[i]) || idle_ok);
        end
    end

    pga_prio #(.NCH(NCH)) u_prio (
        .elig_i (elig),
        .sel_o  (sel),
        .any_o  (any)
    );

    always_comb begin
        c_d    = c_q;
        take_o = '0;
        unique case (c_q.gs)
            GS_HOST: begin
                if (any) begin
                    c_d.gs  = GS_GRANT;
                    c_d.own = sel;
                    take_o  = sel;
                end
            end
            GS_GRANT: c_d.gs = GS_HELD;
            GS_HELD: begin
                if (|(fall_i & c_q.own)) begin
                    c_d.gs  = GS_DEAD;
                    c_d.own = '0;
                end
            end
            GS_DEAD: c_d.gs = GS_HOST;
            default: c_d.gs = GS_HOST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '{gs: GS_HOST, own: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign oe_o         = (c_q.gs == GS_GRANT) ? c_q.own : '0;
    assign owner_held_o = (c_q.gs == GS_HELD) ? c_q.own : '0;
    assign float_o      = (c_q.gs == GS_GRANT) || (c_q.gs == GS_HELD);
    assign hold_o       = (c_q.gs == GS_HELD);

    AST_GRANT_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|oe_o) |=> !(|oe_o));  // R3

    AST_HOLD_FOLLOWS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|oe_o) |=> hold_o);  // R4

    AST_DEAD_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hold_o) |=> !(|oe_o));  // R6

    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|oe_o) |-> ($past(tstate_i) == TS_T4 || $past(tstate_i) == TS_IDLE));  // R7

    AST_T4_ATTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(|oe_o) && $past(tstate_i) == TS_T4)
            |-> !$past(odd_lo_i || inta_first_i || lock_i));  // R8

endmodule

// File: rtl/pulse_grant_arbiter.sv
module pulse_grant_arbiter
    import pga_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [2:0]     tstate_i,
    input  logic           odd_lo_i,
    input  logic           inta_first_i,
    input  logic           lock_i,
    input  logic [NCH-1:0] rqgt_i,
    output logic [NCH-1:0] rqgt_o,
    output logic [NCH-1:0] rqgt_oe_o,
    output logic           bus_float_o,
    output logic           hold_o
);

    logic [NCH-1:0] fall;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] late;
    logic [NCH-1:0] take;
    logic [NCH-1:0] owner_held;
    logic [NCH-1:0] oe;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pga_chan u_chan (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .line_i       (rqgt_i[g]),
            .drive_i      (oe[g]),
            .owner_held_i (owner_held[g]),
            .take_i       (take[g]),
            .tstate_i     (tstate_i),
            .fall_o       (fall[g]),
            .pend_o       (pend[g]),
            .late_o       (late[g])
        );
    end

    pga_ctrl #(.NCH(NCH)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tstate_i     (tstate_i),
        .odd_lo_i     (odd_lo_i),
        .inta_first_i (inta_first_i),
        .lock_i       (lock_i),
        .pend_i       (pend),
        .late_i       (late),
        .fall_i       (fall),
        .oe_o         (oe),
        .take_o       (take),
        .owner_held_o (owner_held),
        .float_o      (bus_float_o),
        .hold_o       (hold_o)
    );

    assign rqgt_o    = '0;
    assign rqgt_oe_o = oe;

    AST_DRIVE_WHILE_FLOATING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rqgt_oe_o) |-> (bus_float_o && !hold_o));  // R3

    AST_SINGLE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rqgt_oe_o));  // R10

endmodule

// File: tb/pulse_grant_arbiter_tb.sv
`timescale 1ns/1ps
module pulse_grant_arbiter_tb;
    import pga_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] ts;
    logic       odd, inta, lk;
    logic [1:0] mlow;
    logic [1:0] line;
    logic [1:0] g_o, g_oe;
    logic       flt, hld;
    int         nchk = 0;
    int         nfail = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            line[i] = mlow[i] ? 1'b0 : (g_oe[i] ? g_o[i] : 1'b1);
        end
    end

    pulse_grant_arbiter #(.NCH(2)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tstate_i     (ts),
        .odd_lo_i     (odd),
        .inta_first_i (inta),
        .lock_i       (lk),
        .rqgt_i       (line),
        .rqgt_o       (g_o),
        .rqgt_oe_o    (g_oe),
        .bus_float_o  (flt),
        .hold_o       (hld)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic pulse(input int ch);
        mlow[ch] = 1'b1;
        tick();
        mlow[ch] = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; mlow = '0; ts = TS_IDLE; odd = 0; inta = 0; lk = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic release_from(input int ch);
        pulse(ch);
        tick();
        tick();
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 oe", g_oe, 0);
        chk("R1 float", flt, 0);
        chk("R1 hold", hld, 0);
    endtask

    task automatic t_idle_grant;
        pulse(0);
        tick();
        chk("R3 oe", g_oe, 1);
        chk("R3 level", g_o[0], 0);
        chk("R3 float", flt, 1);
        chk("R3 hold", hld, 0);
        tick();
        chk("R3 pulse one clock", g_oe, 0);
        chk("R4 hold", hld, 1);
        repeat (3) tick();
        chk("R4 hold kept", hld, 1);
        chk("R4 float kept", flt, 1);
        pulse(0);
        chk("R5 hold dropped", hld, 0);
        chk("R5 float dropped", flt, 0);
        tick();
        chk("R5 no regrant", g_oe, 0);
        tick();
        chk("R5 still host", hld, 0);
    endtask

    task automatic t_priority;
        mlow = 2'b11;
        tick();
        mlow = 2'b00;
        tick();
        chk("R10 ch0 first", g_oe, 1);
        tick();
        chk("R10 held", hld, 1);
        pulse(0);
        chk("R6 hold fell", hld, 0);
        tick();
        chk("R6 dead clock", g_oe, 0);
        tick();
        chk("R6 ch1 after dead", g_oe, 2);
        tick();
        release_from(1);
    endtask

    task automatic t_t4;
        ts = TS_T1; tick();
        ts = TS_T2; mlow[0] = 1'b1; tick();
        mlow[0] = 1'b0; ts = TS_T3; tick();
        chk("R7 no grant before T4", g_oe, 0);
        ts = TS_T4; tick();
        chk("R7 grant after T4", g_oe, 1);
        ts = TS_IDLE; tick();
        release_from(0);
    endtask

    task automatic t_late;
        ts = TS_T1; tick();
        ts = TS_T2; tick();
        ts = TS_T3; mlow[1] = 1'b1; tick();
        mlow[1] = 1'b0; ts = TS_T4; tick();
        chk("R9 late not granted", g_oe, 0);
        ts = TS_T1; tick();
        ts = TS_T2; tick();
        ts = TS_T3; tick();
        chk("R9 waits for T4", g_oe, 0);
        ts = TS_T4; tick();
        chk("R9 granted next T4", g_oe, 2);
        ts = TS_IDLE; tick();
        release_from(1);
    endtask

    task automatic t_attr;
        for (int k = 0; k < 3; k++) begin
            ts = TS_T1; tick();
            ts = TS_T2; mlow[0] = 1'b1;
            odd = (k == 0); inta = (k == 1); lk = (k == 2);
            tick();
            mlow[0] = 1'b0; ts = TS_T3; tick();
            ts = TS_T4; tick();
            chk($sformatf("R8 blocked attr %0d", k), g_oe, 0);
            odd = 0; inta = 0; lk = 0; ts = TS_IDLE;
            tick();
            chk($sformatf("R8 later grant attr %0d", k), g_oe, 1);
            tick();
            release_from(0);
        end
        lk = 1'b1;
        pulse(1);
        tick();
        chk("R8 lock blocks idle", g_oe, 0);
        tick();
        chk("R8 lock still blocks", g_oe, 0);
        lk = 1'b0;
        tick();
        chk("R8 grant after unlock", g_oe, 2);
        tick();
        release_from(1);
    endtask

    task automatic t_wide;
        pulse(0);
        tick();
        tick();
        mlow[1] = 1'b1;
        repeat (3) tick();
        mlow[1] = 1'b0;
        tick();
        pulse(0);
        tick();
        chk("R2 dead", g_oe, 0);
        tick();
        chk("R2 single grant", g_oe, 2);
        tick();
        pulse(1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R2 no second grant", g_oe, 0);
        end
        chk("R2 host owns", hld, 0);
    endtask

    task automatic t_reset_mid;
        pulse(0);
        tick();
        tick();
        pulse(1);
        chk("R11 held before reset", hld, 1);
        rst_n = 1'b0;
        tick();
        chk("R11 hold cleared", hld, 0);
        chk("R11 float cleared", flt, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11 pending dropped", g_oe, 0);
        end
    endtask

    initial begin
        #(200000 * 4);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mlow = '0; ts = TS_IDLE; odd = 0; inta = 0; lk = 0;
        tick();
        t_reset();
        t_idle_grant();
        t_priority();
        t_t4();
        t_late();
        t_attr();
        t_wide();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule